// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block is the retry engine for a transmitter that shares its medium with other stations. A frame request makes the block wait until carrier sense drops. It then issues a one-cycle transmit permit and follows the frame on the wire, counting byte ticks. A collision inside the configured collision window leads to one of two outcomes. Either the frame is retried after a random number of slot times, or, once the retry budget is spent, the frame is dropped with an excessive-collision pulse. A collision after the window is a late collision, and it drops the frame at once. Deferral that lasts too long either drops the frame or keeps waiting, as configuration selects.

The controller has four states. IDLE waits for `frame_req`. DEFER waits for a quiet medium. XMIT follows a frame on the wire. BACKOFF counts the random wait. The transitions are:
- IDLE→DEFER on a frame request.
- DEFER→XMIT when carrier sense is low; the permit is issued in that cycle.
- DEFER→IDLE when the defer limit is reached and sending after an excessive defer is disabled.
- XMIT→IDLE on `tx_done`, on a late collision, or on an excess collision.
- XMIT→BACKOFF on a collision that is retried with a random wait.
- XMIT→DEFER on a collision that is retried immediately.
- BACKOFF→DEFER when the wait counter reaches zero.

Random values come from a free-running 16-bit maximal-length LFSR. The value is masked to the current exponent when the collision is seen.

Top module: `hd_backoff_ctrl`

## Requirements
- R1: After reset, all outputs are low and the block is idle.
- R2: One cycle after `frame_req` in idle, `tx_permit` pulses in the first cycle that `carrier_sense` is low. `frame_req` is ignored outside idle.
- R3: A collision retried with a wait holds `bo_busy` high. The next permit comes exactly 64·s+2 cycles after the collision cycle when byte ticks arrive every cycle, with s a whole number of slots. Carrier sense is ignored while counting.
- R4: With `cfg_alt_en`=0, s lies in 0..2^min(n,10)−1 after the n-th collision, and `cfg_alt_limit` has no effect.
- R5: With `cfg_alt_en`=1, s lies in 0..2^min(n,`cfg_alt_limit`)−1; a limit of 0 gives s=0 always.
- R6: With `cfg_nobo`=1, a retried collision is followed by a permit in the next cycle (gap 1), with no backoff.
- R7: With `cfg_bp_nobo`=1, the immediate retry applies only while `back_pressure`=1; otherwise the normal wait is used.
- R8: With retry maximum m, collision number m+1 of a frame pulses `st_excess_col` and returns to idle without another permit.
- R9: A collision j byte ticks after the permit's following cycle is late when j ≥ `cfg_win`. It pulses `st_late_col` and drops the frame without retry.
- R10: With `cfg_defer_send`=0, carrier held high pulses `st_excess_defer` DEFER_LIMIT+1 cycles after the `frame_req` cycle, and the frame is dropped.
- R11: With `cfg_defer_send`=1, an overlong deferral raises no status, and the permit comes as soon as carrier drops.
- R12: The collision count restarts at each frame start and after `tx_done`.
- R13: Status pulses last one cycle and never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_tick | input | 1 | One pulse per byte time on the wire |
| frame_req | input | 1 | Start a new frame (sampled in idle) |
| tx_done | input | 1 | Current frame finished without collision |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision detected |
| back_pressure | input | 1 | Back-pressure operation active |
| cfg_alt_en | input | 1 | Use programmable truncation exponent |
| cfg_alt_limit | input | 4 | Programmable truncation exponent |
| cfg_nobo | input | 1 | Retry immediately after every collision |
| cfg_bp_nobo | input | 1 | Retry immediately while back pressure is active |
| cfg_defer_send | input | 1 | 1: keep waiting after excessive defer; 0: drop the frame |
| cfg_retry_max | input | 4 | Retries allowed per frame |
| cfg_win | input | 6 | Collision window in byte ticks |
| tx_permit | output | 1 | One-cycle permission to start transmitting |
| bo_busy | output | 1 | Backoff wait in progress |
| st_excess_col | output | 1 | Pulse: frame dropped on excess collisions |
| st_late_col | output | 1 | Pulse: frame dropped on late collision |
| st_excess_defer | output | 1 | Pulse: frame dropped on excessive defer |

## Verification
The permit and the three status pulses are Mealy outputs, so each is due in the same cycle as the event that causes it. The bench drives inputs just after a rising edge and samples at the following falling edge, so each tick observes exactly one cycle. Gaps are counted in ticks from the collision cycle to the permit cycle: a gap of 1 for an immediate retry, 64·s+2 for a wait of s slots, and DEFER_LIMIT+1 ticks from the request to a defer abort. The random slot count cannot be predicted, so the bench checks its arithmetic form and its bound rather than its value.

// File: rtl/bo_pkg.sv
package bo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DEFER   = 2'd1,
        ST_XMIT    = 2'd2,
        ST_BACKOFF = 2'd3
    } bo_state_e;

endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);
    logic fb;

    assign fb = ^(q & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[W-2:0], fb};
    end
endmodule

// File: rtl/bo_sat_counter.sv
module bo_sat_counter #(
    parameter int W   = 6,
    parameter int MAX = 63
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CAP = W'(MAX);

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (clr)                cnt <= '0;
        else if (inc && cnt < CAP)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bo_slot_timer.sv
module bo_slot_timer #(
    parameter int SLOT_W     = 15,
    parameter int SLOT_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOT_W-1:0] slots,
    input  logic              run,
    input  logic              tick,
    output logic              zero
);
    localparam int SHIFT = $clog2(SLOT_BYTES);
    localparam int CW    = SLOT_W + SHIFT;
    localparam bit POW2  = (SHIFT > 0) && ((1 << SHIFT) == SLOT_BYTES);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;

    generate
        if (POW2) begin : g_shift
            assign load_val = {slots, {SHIFT{1'b0}}};
        end else begin : g_mult
            assign load_val = CW'(slots) * CW'(SLOT_BYTES);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (load)                    cnt <= load_val;
        else if (run && tick && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/hd_backoff_ctrl.sv
module hd_backoff_ctrl #(
    parameter int LIM_W       = 4,
    parameter int WIN_W       = 6,
    parameter int STD_EXP     = 10,
    parameter int SLOT_BYTES  = 64,
    parameter int DEFER_LIMIT = 3036,
    parameter int LFSR_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_tick,
    input  logic             frame_req,
    input  logic             tx_done,
    input  logic             carrier_sense,
    input  logic             collision,
    input  logic             back_pressure,
    input  logic             cfg_alt_en,
    input  logic [LIM_W-1:0] cfg_alt_limit,
    input  logic             cfg_nobo,
    input  logic             cfg_bp_nobo,
    input  logic             cfg_defer_send,
    input  logic [LIM_W-1:0] cfg_retry_max,
    input  logic [WIN_W-1:0] cfg_win,
    output logic             tx_permit,
    output logic             bo_busy,
    output logic             st_excess_col,
    output logic             st_late_col,
    output logic             st_excess_defer
);
    import bo_pkg::*;

    localparam int MAX_EXP = (1 << LIM_W) - 1;
    localparam int SLOT_W  = MAX_EXP;
    localparam int EXP_W   = LIM_W + 1;
    localparam int DEF_W   = $clog2(DEFER_LIMIT + 1);
    localparam int WIN_MAX = (1 << WIN_W) - 1;

    bo_state_e state_q, state_d;

    logic [LIM_W-1:0]  att_q;
    logic [LFSR_W-1:0] rnd;
    logic [DEF_W-1:0]  def_cnt;
    logic [WIN_W-1:0]  win_cnt;
    logic              bo_zero;

    logic              coll_ev, late_ev, exc_ev, retry_ev, skip_bo;
    logic              defer_over, defer_abort, start_ev, done_ev;
    logic [EXP_W-1:0]  coll_num, trunc_exp, cur_exp;
    logic [SLOT_W-1:0] slot_mask, slot_draw;

    // Random source
    bo_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .q    (rnd)
    );

    // Deferral length, counted only while waiting on a busy medium
    bo_sat_counter #(.W(DEF_W), .MAX(DEFER_LIMIT)) u_defer_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!(state_q == ST_DEFER && carrier_sense)),
        .inc  (byte_tick),
        .cnt  (def_cnt)
    );

    // Bytes on the wire since the permit, for the collision window
    bo_sat_counter #(.W(WIN_W), .MAX(WIN_MAX)) u_win_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tx_permit),
        .inc  (state_q == ST_XMIT && byte_tick),
        .cnt  (win_cnt)
    );

    // Backoff wait in byte ticks
    bo_slot_timer #(.SLOT_W(SLOT_W), .SLOT_BYTES(SLOT_BYTES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (retry_ev && !skip_bo),
        .slots(slot_draw),
        .run  (state_q == ST_BACKOFF),
        .tick (byte_tick),
        .zero (bo_zero)
    );

    // Event decode
    always_comb begin
        coll_ev     = (state_q == ST_XMIT) && collision;
        late_ev     = coll_ev && (win_cnt >= cfg_win);
        exc_ev      = coll_ev && !late_ev && (att_q == cfg_retry_max);
        retry_ev    = coll_ev && !late_ev && !exc_ev;
        skip_bo     = cfg_nobo || (cfg_bp_nobo && back_pressure);
        defer_over  = (def_cnt >= DEF_W'(DEFER_LIMIT));
        defer_abort = (state_q == ST_DEFER) && carrier_sense && defer_over && !cfg_defer_send;
        start_ev    = (state_q == ST_IDLE) && frame_req;
        done_ev     = (state_q == ST_XMIT) && tx_done && !collision;
    end

    // Truncated exponent and random slot count
    always_comb begin
        coll_num  = {1'b0, att_q} + 1'b1;
        trunc_exp = cfg_alt_en ? {1'b0, cfg_alt_limit} : EXP_W'(STD_EXP);
        cur_exp   = (coll_num < trunc_exp) ? coll_num : trunc_exp;
        slot_mask = ~({SLOT_W{1'b1}} << cur_exp);
        slot_draw = rnd[SLOT_W-1:0] & slot_mask;
    end

    // Collision count of the current frame
    always_ff @(posedge clk) begin
        if (!rst_n)                  att_q <= '0;
        else if (start_ev || done_ev) att_q <= '0;
        else if (retry_ev)           att_q <= att_q + 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_req) state_d = ST_DEFER;
            end
            ST_DEFER: begin
                if (!carrier_sense)   state_d = ST_XMIT;
                else if (defer_abort) state_d = ST_IDLE;
            end
            ST_XMIT: begin
                if (late_ev || exc_ev) state_d = ST_IDLE;
                else if (retry_ev)     state_d = skip_bo ? ST_DEFER : ST_BACKOFF;
                else if (tx_done)      state_d = ST_IDLE;
            end
            ST_BACKOFF: begin
                if (bo_zero) state_d = ST_DEFER;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_permit       = (state_q == ST_DEFER) && !carrier_sense;
        bo_busy         = (state_q == ST_BACKOFF);
        st_excess_col   = exc_ev;
        st_late_col     = late_ev;
        st_excess_defer = defer_abort;
    end

    initial begin
        if (LFSR_W < SLOT_W) $error("LFSR narrower than slot field");
    end
endmodule

// File: rtl/hd_backoff_ctrl_chk.sv
module hd_backoff_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_nobo,
    input logic tx_permit,
    input logic bo_busy,
    input logic st_excess_col,
    input logic st_late_col,
    input logic st_excess_defer
);
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_excess_col, st_late_col, st_excess_defer})); // R13

    AST_STATUS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_excess_col || st_late_col || st_excess_defer) |=>
        !(st_excess_col || st_late_col || st_excess_defer)); // R13

    AST_BUSY_BLOCKS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bo_busy |-> !tx_permit); // R3

    AST_NOBO_SKIPS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bo_busy) |-> !$past(cfg_nobo)); // R6

    AST_EXCESS_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        st_excess_col |=> !bo_busy && !tx_permit); // R8

    AST_LATE_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        st_late_col |=> !bo_busy && !tx_permit); // R9

    AST_DEFER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        st_excess_defer |=> !tx_permit && !bo_busy); // R10
endmodule

bind hd_backoff_ctrl hd_backoff_ctrl_chk u_chk (.*);

// File: tb/hd_backoff_ctrl_bench.sv
module hd_backoff_ctrl_bench;
    localparam int DLIM = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_tick = 1'b1, frame_req = 1'b0, tx_done = 1'b0;
    logic carrier_sense = 1'b0, collision = 1'b0, back_pressure = 1'b0;
    logic cfg_alt_en = 1'b0, cfg_nobo = 1'b0, cfg_bp_nobo = 1'b0, cfg_defer_send = 1'b1;
    logic [3:0] cfg_alt_limit = 4'd10, cfg_retry_max = 4'd15;
    logic [5:0] cfg_win = 6'd55;
    logic tx_permit, bo_busy, st_excess_col, st_late_col, st_excess_defer;

    int checks = 0, errors = 0;
    logic s_permit, s_busy, s_ecol, s_late, s_edef;
    bit cs_follow = 1'b0;

    always #5 clk = ~clk;

    hd_backoff_ctrl #(.DEFER_LIMIT(DLIM)) u_hd_backoff_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .frame_req(frame_req),
        .tx_done(tx_done), .carrier_sense(carrier_sense), .collision(collision),
        .back_pressure(back_pressure), .cfg_alt_en(cfg_alt_en), .cfg_alt_limit(cfg_alt_limit),
        .cfg_nobo(cfg_nobo), .cfg_bp_nobo(cfg_bp_nobo), .cfg_defer_send(cfg_defer_send),
        .cfg_retry_max(cfg_retry_max), .cfg_win(cfg_win), .tx_permit(tx_permit),
        .bo_busy(bo_busy), .st_excess_col(st_excess_col), .st_late_col(st_late_col),
        .st_excess_defer(st_excess_defer)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_le(input string req, input int act, input int lim);
        checks++;
        if (act > lim) begin
            errors++;
            $display("FAIL %s actual=%0d expected<=%0d", req, act, lim);
        end
    endtask

    // Sample one cycle at the falling edge, then move past the next rising edge.
    task automatic tick();
        @(negedge clk);
        s_permit = tx_permit; s_busy = bo_busy; s_ecol = st_excess_col;
        s_late = st_late_col; s_edef = st_excess_defer;
        @(posedge clk);
        #1;
        if (cs_follow) carrier_sense = bo_busy;
    endtask

    task automatic wait_permit(output int n);
        n = 0;
        do begin tick(); n++; end while (!s_permit && n < 5000);
    endtask

    task automatic begin_frame(input string req);
        int n;
        frame_req = 1'b1; tick(); frame_req = 1'b0;
        wait_permit(n);
        chk(req, n, 1);
    endtask

    task automatic collide();
        collision = 1'b1; tick(); collision = 1'b0;
    endtask

    task automatic end_ok();
        tx_done = 1'b1; tick(); tx_done = 1'b0;
    endtask

    // Backoff sweep: gap must be 64*s+2 and s within the truncated range.
    task automatic bo_sweep(input int k_eff, input int ncoll, input int frames,
                            input string req, inout int seen_nz);
        int n, s;
        for (int f = 0; f < frames; f++) begin
            begin_frame("R2");
            for (int c = 1; c <= ncoll; c++) begin
                collide();
                chk("R13", int'(s_ecol) + int'(s_late), 0);
                wait_permit(n);
                chk("R3", (n - 2) % 64, 0);
                s = (n - 2) / 64;
                if (s > 0) seen_nz++;
                chk_le(req, s, (1 << ((c < k_eff) ? c : k_eff)) - 1);
            end
            end_ok();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, cnt, nz, any;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        tick();
        chk("R1 permit", s_permit, 0);
        chk("R1 busy", s_busy, 0);
        chk("R1 status", int'(s_ecol) + int'(s_late) + int'(s_edef), 0);

        // R2: permit waits for quiet medium; frame_req ignored outside idle
        carrier_sense = 1'b1; frame_req = 1'b1; tick(); frame_req = 1'b0;
        any = 0;
        repeat (5) begin tick(); any += int'(s_permit); end
        chk("R2 held", any, 0);
        carrier_sense = 1'b0; tick();
        chk("R2 permit", s_permit, 1);
        frame_req = 1'b1; tick(); frame_req = 1'b0;
        end_ok();
        any = 0;
        repeat (4) begin tick(); any += int'(s_permit); end
        chk("R2 ignored", any, 0);

        // R3, R5: programmable truncation, carrier toggled during the wait
        cs_follow = 1'b1;
        cfg_alt_en = 1'b1;
        for (int k = 0; k <= 3; k++) begin
            cfg_alt_limit = 4'(k);
            nz = 0;
            bo_sweep(k, 5, 2, "R5", nz);
            if (k == 0) chk("R5 zero", nz, 0);
        end

        // R4: standard exponent 10, programmable limit ignored
        cfg_alt_en = 1'b0; cfg_alt_limit = 4'd0;
        nz = 0;
        bo_sweep(10, 3, 4, "R4", nz);
        checks++;
        if (nz == 0) begin errors++; $display("FAIL R4 actual=0 expected>0 nonzero draws"); end
        cs_follow = 1'b0; carrier_sense = 1'b0;

        // R6: immediate retry
        cfg_nobo = 1'b1;
        begin_frame("R2");
        collide(); wait_permit(n);
        chk("R6 gap", n, 1);
        end_ok();
        cfg_nobo = 1'b0;

        // R7: back pressure bypass only while back pressure is active
        cfg_alt_en = 1'b1; cfg_alt_limit = 4'd0; cfg_bp_nobo = 1'b1;
        back_pressure = 1'b1;
        begin_frame("R2");
        collide(); wait_permit(n);
        chk("R7 bp on", n, 1);
        back_pressure = 1'b0;
        collide(); wait_permit(n);
        chk("R7 bp off", n, 2);
        end_ok();
        cfg_bp_nobo = 1'b0;

        // R8: retry maximum sweep
        cfg_nobo = 1'b1; cfg_win = 6'd63;
        for (int m = 0; m <= 5; m++) begin
            cfg_retry_max = (m == 5) ? 4'd15 : 4'(m);
            begin_frame("R2");
            cnt = 0;
            do begin
                collide(); cnt++;
                if (!s_ecol) wait_permit(n);
            end while (!s_ecol && cnt < 20);
            chk("R8 count", cnt, int'(cfg_retry_max) + 1);
            tick();
            chk("R8 stop", int'(s_permit) + int'(s_busy), 0);
            chk("R13 pulse", s_ecol, 0);
        end

        // R12: collision count restarts after a good frame
        cfg_retry_max = 4'd1;
        begin_frame("R2");
        collide(); wait_permit(n);
        end_ok();
        begin_frame("R2");
        collide();
        chk("R12 restart", s_ecol, 0);
        wait_permit(n);
        end_ok();
        cfg_retry_max = 4'd15;

        // R9: collision window sweep
        for (int wi = 0; wi < 4; wi++) begin
            int w;
            w = (wi == 0) ? 0 : (wi == 1) ? 1 : (wi == 2) ? 3 : 8;
            cfg_win = 6'(w);
            for (int j = 0; j <= w + 1; j++) begin
                begin_frame("R2");
                repeat (j) tick();
                collide();
                chk("R9 late", s_late, (j >= w) ? 1 : 0);
                if (s_late) begin
                    tick();
                    chk("R9 no retry", int'(s_permit) + int'(s_busy), 0);
                end else begin
                    wait_permit(n);
                    end_ok();
                end
            end
        end
        cfg_nobo = 1'b0;

        // R10: excessive defer drops the frame
        cfg_defer_send = 1'b0;
        carrier_sense = 1'b1; frame_req = 1'b1; tick(); frame_req = 1'b0;
        n = 0;
        do begin tick(); n++; end while (!s_edef && n < 200);
        chk("R10 time", n, DLIM + 1);
        carrier_sense = 1'b0; tick();
        chk("R10 dropped", s_permit, 0);

        // R11: excessive defer still sends
        cfg_defer_send = 1'b1;
        carrier_sense = 1'b1; frame_req = 1'b1; tick(); frame_req = 1'b0;
        any = 0;
        repeat (2 * DLIM) begin tick(); any += int'(s_edef) + int'(s_permit); end
        chk("R11 no status", any, 0);
        carrier_sense = 1'b0; tick();
        chk("R11 permit", s_permit, 1);
        end_ok();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule